// File: doc/BRIEF.md
# Dual-Supply Rail Select Controller

This controller sits between a memory requester and an SRAM array that can be powered from either of two supply rails: a higher rail used for writes and a lower rail used for reads. On every request it picks the rail the operation needs and drives a pair of registered enables that always form exactly one of the two legal patterns. The controller follows each request without lookahead: one write moves it to the write rail, and one read moves it back to the read rail.

Raising the array supply to the write rail takes time, on the order of 10 ns. An external comparator reports when the rail has arrived. A write is held until that report arrives, and it then reaches the array. The requester keeps its address and data steady during the wait. Lowering the supply needs no wait, because every voltage on the way down is safe for reads. A read is therefore accepted and strobed in the cycle it is presented, and the enables flip at the end of that same cycle. Two counters record how often the rail changes and how many cycles writes spent waiting.

Top module: `rail_select_ctrl`

## Requirements
- R1: `wr_rail_en` and `rd_rail_en` are registered, change on the same clock edge, and always hold opposite values. Pattern 1/0 selects the write rail and 0/1 selects the read rail.
- R2: After a clock edge at which a write request was presented, the write rail is selected. After an edge at which a read request was presented, the read rail is selected. With `req_valid` low, the selection holds.
- R3: `mem_wr_stb` is high only when a write is presented, the write rail is selected and `wr_rail_ready` is high. Until then `req_accept` stays low. With a ramp of D cycles, a write that arrives on the read rail is accepted D+1 cycles after it is first presented.
- R4: A read is accepted, with `mem_rd_stb` high, in the same cycle it is presented, whichever rail is selected.
- R5: While reset (`rst_n` low) is active, the read rail is selected, both counters are zero, and no strobe or accept is driven while `req_valid` is low.
- R6: During an access strobe, `mem_addr` and `mem_wdata` equal the presented request's address and data.
- R7: `rail_switch_count` increments by one at every edge where the rail selection changes, and is otherwise unchanged.
- R8: `write_wait_count` increments by one for each cycle in which a write is presented but not accepted.
- R9: With `req_valid` low, `wr_rail_ready` has no effect: no strobe, no accept, no counter change and no rail change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| wr_rail_ready | input | 1 | Comparator: array supply has reached the write rail |
| wr_rail_en | output | 1 | Enable for the write rail |
| rd_rail_en | output | 1 | Enable for the read rail |
| req_accept | output | 1 | Request taken this cycle |
| mem_rd_stb | output | 1 | Array read strobe |
| mem_wr_stb | output | 1 | Array write strobe |
| mem_addr | output | AW | Array address |
| mem_wdata | output | DW | Array write data |
| rail_switch_count | output | CW | Number of rail changes |
| write_wait_count | output | CW | Total cycles writes were stalled |

## Verification
The bench builds the block with AW=6, DW=8 and CW=8. These widths keep the counters small, and the bench still checks every counter value exactly. It models the comparator as a ramp of programmable length and sweeps every delay from 0 to 5 cycles. Each ramp length runs the same mix: a read on the read rail, a write that forces a rail change, a back-to-back write, idle cycles, and reads that flip the rail back. The bench derives the expected stall length (D+1) and the running counter totals arithmetically from the delay and the request sequence.

// File: rtl/rail_select_ctrl.sv
module rail_select_ctrl #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          wr_rail_ready,
  output logic          wr_rail_en,
  output logic          rd_rail_en,
  output logic          req_accept,
  output logic          mem_rd_stb,
  output logic          mem_wr_stb,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [CW-1:0] rail_switch_count,
  output logic [CW-1:0] write_wait_count
);

  logic wr_en_q, rd_en_q;
  logic [CW-1:0] sw_cnt_q, wait_cnt_q;

  wire want_wr = req_valid & req_write;
  wire want_rd = req_valid & ~req_write;
  wire flip    = (want_wr & ~wr_en_q) | (want_rd & wr_en_q);

  assign wr_rail_en        = wr_en_q;
  assign rd_rail_en        = rd_en_q;
  assign mem_rd_stb        = want_rd;
  assign mem_wr_stb        = want_wr & wr_en_q & wr_rail_ready;
  assign req_accept        = mem_rd_stb | mem_wr_stb;
  assign mem_addr          = req_addr;
  assign mem_wdata         = req_wdata;
  assign rail_switch_count = sw_cnt_q;
  assign write_wait_count  = wait_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q    <= 1'b0;
      rd_en_q    <= 1'b1;
      sw_cnt_q   <= '0;
      wait_cnt_q <= '0;
    end else begin
      if (flip) begin
        wr_en_q  <= rd_en_q;
        rd_en_q  <= wr_en_q;
        sw_cnt_q <= sw_cnt_q + 1'b1;
      end
      if (want_wr && !mem_wr_stb)
        wait_cnt_q <= wait_cnt_q + 1'b1;
    end
  end

  AST_ENABLES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rail_en != rd_rail_en); // R1
  AST_TO_WRITE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> wr_rail_en && !rd_rail_en); // R2
  AST_TO_READ_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |=> rd_rail_en && !wr_rail_en); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(wr_rail_en)); // R9
  AST_WR_ON_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_stb |-> wr_rail_en && wr_rail_ready); // R3
  AST_READ_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |-> req_accept); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_stb && mem_wr_stb)); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && !req_accept |=>
      req_valid && req_write && $stable(req_addr) && $stable(req_wdata)); // R6
  AST_SWITCH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(wr_rail_en) |-> rail_switch_count == $past(rail_switch_count) + 1'b1); // R7
  AST_WAIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write && !req_accept |=> write_wait_count != $past(write_wait_count)); // R8

endmodule

// File: tb/rail_select_ctrl_test.sv
module rail_select_ctrl_test;
  localparam int AW = 6, DW = 8, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic wr_rail_ready;
  logic wr_rail_en, rd_rail_en, req_accept, mem_rd_stb, mem_wr_stb;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [CW-1:0] rail_switch_count, write_wait_count;

  int checks = 0, failures = 0;
  int ramp_dly = 0;
  int exp_sw = 0, exp_wait = 0;
  bit cur_wr = 1'b0;
  logic [7:0] ramp_cnt;

  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ramp_cnt <= '0;
    else if (!wr_rail_en) ramp_cnt <= '0;
    else if (ramp_cnt != 8'hff) ramp_cnt <= ramp_cnt + 8'd1;
  assign wr_rail_ready = wr_rail_en && (int'(ramp_cnt) >= ramp_dly);

  rail_select_ctrl #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .wr_rail_ready(wr_rail_ready),
    .wr_rail_en(wr_rail_en), .rd_rail_en(rd_rail_en), .req_accept(req_accept),
    .mem_rd_stb(mem_rd_stb), .mem_wr_stb(mem_wr_stb), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rail_switch_count(rail_switch_count),
    .write_wait_count(write_wait_count));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (ramp=%0d, t=%0t)", req, act, exp, ramp_dly, $time);
    end
  endtask

  task automatic check_rails(input string req);
    check(wr_rail_en == cur_wr && rd_rail_en == !cur_wr, req,
          {wr_rail_en, rd_rail_en}, {cur_wr, !cur_wr});
  endtask

  task automatic check_counts();
    check(rail_switch_count == CW'(exp_sw), "R7 switch count", rail_switch_count, exp_sw);
    check(write_wait_count == CW'(exp_wait), "R8 wait count", write_wait_count, exp_wait);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int waited = 0;
    int want = cur_wr ? 0 : ramp_dly + 1;
    bit early = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #2;
    while (!req_accept && waited < 50) begin
      if (mem_wr_stb) early = 1'b1;
      @(negedge clk); #2;
      waited++;
    end
    check(waited == want, "R3 write stall length", waited, want);
    check(!early && mem_wr_stb, "R3 write strobe only when ready", mem_wr_stb, 1);
    check(mem_addr == a && mem_wdata == d, "R6 write address/data", {mem_addr, mem_wdata}, {a, d});
    if (!cur_wr) exp_sw++;
    cur_wr = 1'b1;
    exp_wait += want;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check_rails("R2 write selects write rail");
    check_counts();
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h5a;
    #2;
    check(req_accept && mem_rd_stb && !mem_wr_stb, "R4 read accepted at once",
          {req_accept, mem_rd_stb, mem_wr_stb}, 3'b110);
    check(mem_addr == a, "R6 read address", mem_addr, a);
    if (cur_wr) exp_sw++;
    cur_wr = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check_rails("R2 read selects read rail");
    check_counts();
  endtask

  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      check(!mem_wr_stb && !mem_rd_stb && !req_accept, "R9 idle no strobe",
            {mem_wr_stb, mem_rd_stb, req_accept}, 0);
      check_rails("R9 idle rail hold");
      check_counts();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(rd_rail_en && !wr_rail_en, "R5 reset rail", {wr_rail_en, rd_rail_en}, 2'b01);
    check(rail_switch_count == 0 && write_wait_count == 0, "R5 reset counters",
          rail_switch_count + write_wait_count, 0);
    check(!req_accept && !mem_rd_stb && !mem_wr_stb, "R5 reset no strobe",
          {req_accept, mem_rd_stb, mem_wr_stb}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle_check(2);
    for (int d = 0; d <= 5; d++) begin
      ramp_dly = d;
      do_read(AW'(d));
      do_write(AW'(8 + d), DW'(16 * d + 1));
      do_write(AW'(16 + d), DW'(16 * d + 2));
      idle_check(3);
      do_read(AW'(24 + d));
      do_read(AW'(32 + d));
      idle_check(1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule